// File: doc/BRIEF.md
# Programmable Input Deglitch Filter

This block cleans up a bank of 8-bit digital input ports before their lines are read or passed to edge detection. Each raw pin is first brought into the clock domain by a two-stage synchroniser. A line that is selected for filtering only moves its output after its synchronised input has held a new level for a programmed number of time-base ticks. A line that is not selected passes the synchronised level straight through.

Every filtered line on every port uses the same interval register. That interval counts ticks of a shared time base, and each tick lasts `TICK_DIV` system clocks, which gives 200 ns at 50 MHz when `TICK_DIV` is 10. Each port has an 8-bit mask register with one bit per line that selects which lines are filtered. Software programs and reads both kinds of register over a simple synchronous register bus.

Top module: `deglitch_bank`

## Requirements
- R1: After reset the interval register and every mask read as zero, and each output follows its synchronised pin, so no line is filtered.
- R2: The interval register sits at byte address 0x08 and stores bits 19:0 of the written word. Bits 31:20 always read as zero, so writing 0xFFFFFFFF reads back 0x000FFFFF.
- R3: The mask of port p sits at byte address 0x44 + 0x10·p. It stores the written bits 7:0, where bit b selects line p·8+b of the pin vectors, and it reads back with bits 31:8 at zero.
- R4: A read from any other address returns zero. A write to any other address changes no register.
- R5: On a line whose mask bit is clear, the output takes a new pin level after exactly two clock edges.
- R6: On a filtered line, the output never changes while the synchronised input differs from it for W clock edges with W ≤ (N−1)·TICK_DIV, where N is the interval. A return to the output's level before the interval completes restarts the count, so two such pulses separated by a short gap are both rejected.
- R7: On a filtered line with interval N ≥ 1, a lasting pin change appears at the output no earlier than 3+(N−1)·TICK_DIV clock edges and no later than 2+N·TICK_DIV edges after the pin changes. Ticks are spaced TICK_DIV clocks apart.
- R8: With an interval of zero, filtered lines behave like unfiltered ones (R5).
- R9: When a line's mask bit is cleared, its output shows the synchronised input from the clock edge that writes the mask onward, even if a filter count is still pending.
- R10: Filtered lines on different ports follow the same interval independently of each other, and unfiltered lines next to them keep the timing of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, sampled on the clock edge |
| reg_wr_addr | input | 8 | Register write byte address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 8 | Register read byte address |
| reg_rd_data | output | 32 | Read data for reg_rd_addr, combinational |
| pin_in | input | NUM_PORTS·PORT_W | Raw input pins, line p·8+b is port p bit b |
| pin_filt | output | NUM_PORTS·PORT_W | Filtered or bypassed line levels |

## Verification
On an unfiltered line the output is due two edges after a pin change, one edge per synchroniser stage. Register writes take effect at the edge that samples the strobe, and read data appears within the same cycle. A filtered line's output is due inside a window whose edges depend on the tick phase: from 3+(N−1)·TICK_DIV to 2+N·TICK_DIV edges. The bench therefore checks that the old value still holds at the early bound minus one and that the new value has arrived at the late bound. Inputs change on the falling edge and outputs are sampled there, so every check falls a whole number of rising edges after its stimulus.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  // Width of the stored interval (maximum 0xFFFFF ticks).
  localparam int unsigned IVL_BITS = 20;
  localparam int unsigned BUS_W = 32;
  localparam logic [7:0] IVL_OFFSET = 8'h08;
  localparam logic [7:0] MASK_BASE = 8'h44;
  localparam logic [7:0] PORT_STRIDE = 8'h10;

  // Byte address of the enable mask belonging to one port.
  function automatic logic [7:0] mask_offset(input int unsigned port);
    return 8'(MASK_BASE + 8'(port) * PORT_STRIDE);
  endfunction

  // True when one more tick completes the programmed stability interval.
  function automatic logic ticks_done(input logic [IVL_BITS-1:0] cnt,
                                      input logic [IVL_BITS-1:0] ivl);
    return ({1'b0, cnt} + {{IVL_BITS{1'b0}}, 1'b1}) >= {1'b0, ivl};
  endfunction
endpackage

// File: rtl/dgf_tick.sv
module dgf_tick #(
  parameter int unsigned TICK_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);

  generate
    if (TICK_DIV > 1) begin : g_spacing
      // R7
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/dgf_regs.sv
module dgf_regs
  import dgf_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [7:0]                    wr_addr,
  input  logic [BUS_W-1:0]              wr_data,
  input  logic [7:0]                    rd_addr,
  output logic [BUS_W-1:0]              rd_data,
  output logic [IVL_BITS-1:0]           ivl,
  output logic [NUM_PORTS*PORT_W-1:0]   mask
);
  logic [IVL_BITS-1:0]                ivl_q;
  logic [NUM_PORTS-1:0][PORT_W-1:0]   mask_q;
  logic                               unused_hi;

  assign unused_hi = ^wr_data[BUS_W-1:IVL_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               ivl_q <= '0;
    else if (wr_en && wr_addr == IVL_OFFSET)  ivl_q <= wr_data[IVL_BITS-1:0];
  end

  // R2
  ivl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == IVL_OFFSET) |=> ivl_q == $past(wr_data[IVL_BITS-1:0]));

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 mask_q[p] <= '0;
        else if (wr_en && wr_addr == mask_offset(p)) mask_q[p] <= wr_data[PORT_W-1:0];
      end

      // R4
      mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == mask_offset(p)) |=> $stable(mask_q[p]));
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (rd_addr == IVL_OFFSET) rd_data[IVL_BITS-1:0] = ivl_q;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (rd_addr == mask_offset(p)) rd_data[PORT_W-1:0] = mask_q[p];
    end
  end

  assign ivl  = ivl_q;
  assign mask = mask_q;
endmodule

// File: rtl/dgf_line.sv
module dgf_line
  import dgf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pin,
  input  logic                tick,
  input  logic                enable,
  input  logic [IVL_BITS-1:0] ivl,
  output logic                bypass,
  output logic                out
);
  logic [1:0]          sync_q;
  logic                held_q;
  logic [IVL_BITS-1:0] cnt_q;
  logic                level;
  logic                differ;
  logic                advance;
  logic                commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], pin};
  end

  assign level   = sync_q[1];
  assign bypass  = !enable || (ivl == '0);
  assign differ  = (level != held_q);
  assign advance = !bypass && differ && tick;
  assign commit  = advance && ticks_done(cnt_q, ivl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      cnt_q  <= '0;
    end else if (bypass) begin
      held_q <= level;
      cnt_q  <= '0;
    end else if (!differ) begin
      cnt_q  <= '0;
    end else if (commit) begin
      held_q <= level;
      cnt_q  <= '0;
    end else if (advance) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign out = bypass ? level : held_q;

  // R7
  held_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !tick) |=> $stable(held_q));

  // R6
  count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !differ) |=> cnt_q == '0);

  // R6
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && differ && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/deglitch_bank.sv
module deglitch_bank
  import dgf_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned TICK_DIV  = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr_en,
  input  logic [7:0]                  reg_wr_addr,
  input  logic [31:0]                 reg_wr_data,
  input  logic [7:0]                  reg_rd_addr,
  output logic [31:0]                 reg_rd_data,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic [NUM_PORTS*PORT_W-1:0] pin_filt
);
  localparam int unsigned LINES = NUM_PORTS * PORT_W;

  logic                tick;
  logic [IVL_BITS-1:0] ivl;
  logic [LINES-1:0]    mask;
  logic [LINES-1:0]    bypass_vec;

  dgf_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  dgf_regs #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data),
    .rd_addr (reg_rd_addr),
    .rd_data (reg_rd_data),
    .ivl     (ivl),
    .mask    (mask)
  );

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      dgf_line u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (pin_in[i]),
        .tick   (tick),
        .enable (mask[i]),
        .ivl    (ivl),
        .bypass (bypass_vec[i]),
        .out    (pin_filt[i])
      );
    end
  endgenerate

  // R9
  mask_clear_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == mask_offset(0) && reg_wr_data[0] == 1'b0)
      |=> bypass_vec[0]);

  // R2
  ivl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_addr == IVL_OFFSET) |-> reg_rd_data[31:IVL_BITS] == '0);
endmodule

// File: tb/deglitch_bank_bench.sv
module deglitch_bank_bench;
  localparam int CLK_PERIOD = 20;
  localparam int NP  = 4;
  localparam int PW  = 8;
  localparam int DIV = 10;
  localparam int NL  = NP * PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [7:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic [NL-1:0] pins = '0;
  logic [NL-1:0] filt;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  deglitch_bank #(.NUM_PORTS(NP), .PORT_W(PW), .TICK_DIV(DIV)) u_deglitch_bank (
    .clk (clk), .rst_n (rst_n),
    .reg_wr_en (wr_en), .reg_wr_addr (wr_addr), .reg_wr_data (wr_data),
    .reg_rd_addr (rd_addr), .reg_rd_data (rd_data),
    .pin_in (pins), .pin_filt (filt)
  );

  function automatic logic [7:0] mask_addr(input int p);
    return 8'(8'h44 + p * 16);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(filt == '0, "R1 outputs in reset", filt, 0);
    edges(3);
    rst_n = 1'b1;
    edges(1);
    rd(8'h08, v);
    check(v == 0, "R1 interval after reset", v, 0);
    for (int p = 0; p < NP; p++) begin
      rd(mask_addr(p), v);
      check(v == 0, "R1 mask after reset", v, 0);
    end
    pins = 32'hA55A_3CC3;
    edges(2);
    check(filt == 32'hA55A_3CC3, "R1 pass-through after reset", filt, 32'hA55A_3CC3);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v);
    check(v == 32'h000F_FFFF, "R2 interval upper bits", v, 32'h000F_FFFF);
    wr(8'h08, 32'h0001_2345);
    rd(8'h08, v);
    check(v == 32'h0001_2345, "R2 interval value", v, 32'h0001_2345);
    for (int p = 0; p < NP; p++) wr(mask_addr(p), 32'hFFFF_FF00 | (p * 8'h11 + 3));
    for (int p = 0; p < NP; p++) begin
      rd(mask_addr(p), v);
      check(v == 32'(p * 8'h11 + 3), "R3 mask readback", v, 32'(p * 8'h11 + 3));
    end
    wr(8'h45, 32'hFF);
    rd(8'h45, v);
    check(v == 0, "R4 unmapped read", v, 0);
    rd(mask_addr(0), v);
    check(v == 32'h3, "R4 unmapped write ignored", v, 32'h3);
    for (int p = 0; p < NP; p++) wr(mask_addr(p), 0);
    wr(8'h08, 0);
  endtask

  task automatic t_bypass();
    pins = 32'h0F0F_1234;
    edges(1);
    check(filt == 32'hA55A_3CC3, "R5 one edge still old", filt, 32'hA55A_3CC3);
    edges(1);
    check(filt == 32'h0F0F_1234, "R5 two edges new", filt, 32'h0F0F_1234);
  endtask

  task automatic t_zero_interval();
    wr(mask_addr(0), 32'hFF);
    pins[7:0] = 8'h96;
    edges(2);
    check(filt[7:0] == 8'h96, "R8 zero interval passes", filt[7:0], 8'h96);
  endtask

  task automatic t_window();
    pins = '0;
    edges(4);
    wr(8'h08, 3);
    wr(mask_addr(0), 32'h01);
    wr(mask_addr(1), 32'h02);
    edges(3);
    pins[0] = 1'b1; pins[9] = 1'b1; pins[2] = 1'b1;
    edges(2);
    check(filt[2] == 1'b1, "R10 unfiltered neighbour", filt[2], 1);
    check(filt[0] == 1'b0 && filt[9] == 1'b0, "R7 filtered not yet", {filt[9], filt[0]}, 0);
    edges(20);
    check(filt[0] == 1'b0 && filt[9] == 1'b0, "R7 early bound", {filt[9], filt[0]}, 0);
    edges(10);
    check(filt[0] == 1'b1, "R7 late bound", filt[0], 1);
    check(filt[9] == 1'b1, "R10 second port same interval", filt[9], 1);
  endtask

  task automatic t_glitch();
    bit ok = 1'b1;
    pins[0] = 1'b0;
    for (int i = 0; i < 20; i++) begin edges(1); if (filt[0] != 1'b1) ok = 1'b0; end
    pins[0] = 1'b1;
    for (int i = 0; i < 2; i++)  begin edges(1); if (filt[0] != 1'b1) ok = 1'b0; end
    pins[0] = 1'b0;
    for (int i = 0; i < 20; i++) begin edges(1); if (filt[0] != 1'b1) ok = 1'b0; end
    pins[0] = 1'b1;
    for (int i = 0; i < 40; i++) begin edges(1); if (filt[0] != 1'b1) ok = 1'b0; end
    check(ok, "R6 glitches rejected and count restarted", filt[0], 1);
  endtask

  task automatic t_disable();
    wr(8'h08, 1000);
    pins[0] = 1'b0;
    edges(5);
    check(filt[0] == 1'b1, "R9 long interval holds", filt[0], 1);
    wr(mask_addr(0), 0);
    check(filt[0] == 1'b0, "R9 cleared enable bypasses", filt[0], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_regs();
    t_bypass();
    t_zero_interval();
    t_window();
    t_glitch();
    t_disable();
    finish_run();
  end
endmodule